// File: doc/BRIEF.md
# Dual Alarm Comparator with Interrupt Routing

This block holds two independent alarm settings. Each setting has four one-byte fields: seconds, minutes, hours and weekday. On every seconds-update strobe from an external timekeeper, each alarm's fields are compared with the running time. When an alarm matches, the block raises a pending flag for that alarm. An enabled flag drives one of two active-low interrupt pins.

Software uses a simple byte-wide register port with separate read and write strobes. Read data is registered.

- Any alarm field can be excluded from the compare, so an alarm can fire every minute, every hour, and so on.
- A control register holds one enable bit per alarm and a routing bit. The routing bit selects whether alarm 1 shares pin 0 with alarm 0 or uses pin 1.
- Software acknowledges an alarm in either of two ways: by reading any register of that alarm, or by writing a zero to the alarm's flag bit.

Top module: `alarm_cmp`

## Requirements
- R1: Alarm 0 fields sit at addresses 0x07 (seconds), 0x08 (minutes), 0x09 (hours) and 0x0A (weekday). Alarm 1 fields sit at 0x0B to 0x0E in the same order. A written value reads back on `bus_rdata` in the cycle after the read strobe.
- R2: After reset, all alarm fields, the control register and the status register are zero, and both interrupt pins are high.
- R3: An alarm flag is set only in a cycle where `tick` is high and every compared field of that alarm equals the matching time input. A matching time without `tick` sets nothing.
- R4: A field whose bit 7 is 1 is excluded from the compare. The alarm's other fields are still compared.
- R5: The hours field is compared on its raw byte, including bit 6 (12-hour format) and bit 5 (PM). An alarm written in 24-hour form does not match a time given in 12-hour form.
- R6: The status register at 0x10 shows the alarm 0 flag in bit 0 and the alarm 1 flag in bit 1. Bits 7:2 read 0. A flag is set even when its interrupt is disabled.
- R7: Reading any register of an alarm clears that alarm's flag and leaves the other flag unchanged. Reading the status register clears nothing.
- R8: Writing the status register clears each flag whose bit is written 0. Writing 1 to a bit leaves that flag unchanged.
- R9: The control register at 0x0F has three bits: bit 0 enables alarm 0, bit 1 enables alarm 1, and bit 2 routes alarm 1 to pin 1. Bits 7:3 read 0.
- R10: `irq0_n` is low while (alarm 0 flag and enable 0) are set, or while (alarm 1 flag and enable 1) are set and bit 2 is clear. `irq1_n` is low while alarm 1 flag and enable 1 are set and bit 2 is set. The pins are registered and change on the same clock edge as the flag or control bit that causes the change.
- R11: If a match and an acknowledge of the same alarm fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick | input | 1 | One-cycle strobe marking a seconds update |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hour | input | 8 | Current hours byte |
| now_wday | input | 8 | Current weekday byte |
| irq0_n | output | 1 | Interrupt pin 0, active low |
| irq1_n | output | 1 | Interrupt pin 1, active low |

## Verification
The compare is tested with several time patterns:

- A matching time held without a strobe, which shows that only `tick` arms a match.
- A time off by one second, which shows that an exact compare is required.
- A fully masked alarm against an arbitrary time.
- A partly masked alarm with one unmasked field changed, which shows that masking is per field.

The hours byte is presented once in 12-hour form against a 24-hour alarm, and then again after the alarm is rewritten in 12-hour form. This shows that the compare works on the raw encoding.

Both routing settings, disabled versus enabled flags, and a strobe that coincides with an acknowledge show whether each pin follows the correct flag and whether a new event survives a simultaneous clear.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int FIELDS   = 4;
  localparam int NUM_ALM  = 2;
  localparam int CTRL_W   = 3;

  localparam logic [ADDR_W-1:0] ALM_BASE  = 8'h07;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h0F;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h10;

  // control bit positions
  localparam int EN0_BIT   = 0;
  localparam int EN1_BIT   = 1;
  localparam int ROUTE_BIT = 2;
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int FIELDS = 4,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          tick,
  input  logic [FIELDS-1:0][DATA_W-1:0] now,
  output logic                          fire,
  output logic                          acked,
  output logic [DATA_W-1:0]             rd_val
);
  localparam int OFF_W = (FIELDS > 1) ? $clog2(FIELDS) : 1;
  localparam int LIMIT = int'(BASE) + FIELDS;

  logic [FIELDS-1:0][DATA_W-1:0] fld;
  logic [FIELDS-1:0]             eq;
  logic                          in_range;
  logic [ADDR_W-1:0]             off;

  assign in_range = (int'(addr) >= int'(BASE)) && (int'(addr) < LIMIT);
  assign off      = addr - BASE;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        fld[i] <= '0;
      else if (wr && (addr == BASE + ADDR_W'(i)))
        fld[i] <= wdata;
    end
    // top bit masks the field out of the compare
    assign eq[i] = fld[i][DATA_W-1] |
                   (fld[i][DATA_W-2:0] == now[i][DATA_W-2:0]);
  end

  assign fire   = tick & (&eq);
  assign acked  = rd & in_range;
  assign rd_val = in_range ? fld[off[OFF_W-1:0]] : '0;
endmodule

// File: rtl/alarm_events.sv
module alarm_events #(
  parameter int DATA_W  = 8,
  parameter int NUM_ALM = 2,
  parameter int CTRL_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic               stat_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_ALM-1:0] fire,
  input  logic [NUM_ALM-1:0] acked,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [NUM_ALM-1:0] flag_q,
  output logic               irq0_n,
  output logic               irq1_n
);
  import alarm_cmp_pkg::*;

  logic [NUM_ALM-1:0] flag_nxt;
  logic [CTRL_W-1:0]  ctrl_nxt;
  logic               req0, req1;

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_flag
    // a new match wins over any clear in the same cycle
    assign flag_nxt[a] = fire[a] |
                         (flag_q[a] & ~acked[a] & ~(stat_wr & ~wdata[a]));
  end

  assign ctrl_nxt = ctrl_wr ? wdata[CTRL_W-1:0] : ctrl_q;

  assign req0 = (flag_nxt[0] & ctrl_nxt[EN0_BIT]) |
                (flag_nxt[1] & ctrl_nxt[EN1_BIT] & ~ctrl_nxt[ROUTE_BIT]);
  assign req1 =  flag_nxt[1] & ctrl_nxt[EN1_BIT] &  ctrl_nxt[ROUTE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ctrl_q <= '0;
      irq0_n <= 1'b1;
      irq1_n <= 1'b1;
    end else begin
      flag_q <= flag_nxt;
      ctrl_q <= ctrl_nxt;
      irq0_n <= ~req0;
      irq1_n <= ~req1;
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int DATA_W = alarm_cmp_pkg::DATA_W,
  parameter int ADDR_W = alarm_cmp_pkg::ADDR_W,
  parameter int FIELDS = alarm_cmp_pkg::FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic [DATA_W-1:0] now_sec,
  input  logic [DATA_W-1:0] now_min,
  input  logic [DATA_W-1:0] now_hour,
  input  logic [DATA_W-1:0] now_wday,
  output logic              irq0_n,
  output logic              irq1_n
);
  import alarm_cmp_pkg::*;

  logic [FIELDS-1:0][DATA_W-1:0]  now_vec;
  logic [NUM_ALM-1:0]             fire_w, ack_w, flag_w;
  logic [NUM_ALM-1:0][DATA_W-1:0] slot_val;
  logic [CTRL_W-1:0]              ctrl_w;
  logic                           ctrl_wr, stat_wr;
  logic [DATA_W-1:0]              rd_mux;

  assign now_vec = {now_wday, now_hour, now_min, now_sec};
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alarm
    localparam logic [ADDR_W-1:0] SLOT_BASE =
      ADDR_W'(ALM_BASE) + ADDR_W'(a * FIELDS);
    alarm_slot #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .FIELDS (FIELDS),
      .BASE   (SLOT_BASE)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .wdata  (bus_wdata),
      .tick   (tick),
      .now    (now_vec),
      .fire   (fire_w[a]),
      .acked  (ack_w[a]),
      .rd_val (slot_val[a])
    );
  end

  alarm_events #(
    .DATA_W  (DATA_W),
    .NUM_ALM (NUM_ALM),
    .CTRL_W  (CTRL_W)
  ) u_events (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .stat_wr (stat_wr),
    .wdata   (bus_wdata),
    .fire    (fire_w),
    .acked   (ack_w),
    .ctrl_q  (ctrl_w),
    .flag_q  (flag_w),
    .irq0_n  (irq0_n),
    .irq1_n  (irq1_n)
  );

  always_comb begin
    rd_mux = '0;
    for (int a = 0; a < NUM_ALM; a++)
      rd_mux = rd_mux | slot_val[a];
    if (bus_addr == ADDR_W'(CTRL_ADDR))
      rd_mux = DATA_W'(ctrl_w);
    if (bus_addr == ADDR_W'(STAT_ADDR))
      rd_mux = DATA_W'(flag_w);
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_rd,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       irq0_n,
  input logic       irq1_n,
  input logic [1:0] fire_w,
  input logic [1:0] flag_w,
  input logic [2:0] ctrl_w
);
  // R3
  fire0_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fire_w[0] |=> flag_w[0]);
  // R3
  fire1_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fire_w[1] |=> flag_w[1]);
  // R7
  ack0_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= 8'h07 && bus_addr <= 8'h0A && !fire_w[0])
      |=> !flag_w[0]);
  // R6
  stat_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h10) |=> (bus_rdata[7:2] == 6'd0));
  // R9
  ctrl_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h0F) |=> (bus_rdata[7:3] == 5'd0));
  // R10
  route_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_w[2] |-> irq1_n);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_w == 2'b00) |-> (irq0_n && irq1_n));
endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq0_n    (irq0_n),
  .irq1_n    (irq1_n),
  .fire_w    (fire_w),
  .flag_w    (flag_w),
  .ctrl_w    (ctrl_w)
);

// File: tb/alarm_cmp_test.sv
module alarm_cmp_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
  logic       irq0_n, irq1_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  alarm_cmp uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_wday(now_wday),
    .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0)
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_now(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w);
    now_sec = s; now_min = m; now_hour = h; now_wday = w;
  endtask

  task automatic tk(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w);
    @(negedge clk);
    set_now(s, m, h, w); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tk_rd(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w,
                       logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    set_now(s, m, h, w); tick = 1'b1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pins(logic e0, logic e1, string tag);
    check(tag, {6'd0, irq1_n, irq0_n}, {6'd0, e1, e0});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    pins(1'b1, 1'b1, "R2 pins after reset");
    rd(8'h0F, 8'h00, "R2 control after reset");
    rd(8'h10, 8'h00, "R2 status after reset");
    rd(8'h07, 8'h00, "R2 alarm field after reset");

    // R1 alarm 0 write and readback
    wr(8'h07, 8'h30); wr(8'h08, 8'h15); wr(8'h09, 8'h08); wr(8'h0A, 8'h03);
    rd(8'h07, 8'h30, "R1 alarm0 sec");
    rd(8'h08, 8'h15, "R1 alarm0 min");
    rd(8'h09, 8'h08, "R1 alarm0 hour");
    rd(8'h0A, 8'h03, "R1 alarm0 wday");

    // R9 control width
    wr(8'h0F, 8'hFF);
    rd(8'h0F, 8'h07, "R9 control unused bits");
    wr(8'h0F, 8'h00);

    // R3 match without tick, then off-by-one, then match
    @(negedge clk); set_now(8'h30, 8'h15, 8'h08, 8'h03);
    repeat (2) @(negedge clk);
    rd(8'h10, 8'h00, "R3 no tick no flag");
    tk(8'h31, 8'h15, 8'h08, 8'h03);
    rd(8'h10, 8'h00, "R3 seconds mismatch");
    tk(8'h30, 8'h15, 8'h08, 8'h03);
    rd(8'h10, 8'h01, "R6 flag set while disabled");
    rd(8'h10, 8'h01, "R7 status read keeps flag");
    pins(1'b1, 1'b1, "R10 disabled flag no pin");

    // R10 enable alarm 0
    wr(8'h0F, 8'h01);
    pins(1'b0, 1'b1, "R10 enable0 asserts pin0");
    // R7 acknowledge by reading
    rd(8'h0B, 8'h00, "R7 read other alarm");
    rd(8'h10, 8'h01, "R7 other alarm read keeps flag0");
    rd(8'h09, 8'h08, "R7 read alarm0 hour");
    rd(8'h10, 8'h00, "R7 alarm0 read clears flag0");
    pins(1'b1, 1'b1, "R7 pin released after ack");

    // R4 fully masked alarm 1, R10 routing
    wr(8'h0B, 8'h80); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80); wr(8'h0E, 8'h80);
    wr(8'h0F, 8'h02);
    tk(8'h45, 8'h59, 8'h23, 8'h07);
    rd(8'h10, 8'h02, "R4 masked alarm1 matches any time");
    pins(1'b0, 1'b1, "R10 alarm1 on pin0 when route clear");
    wr(8'h0F, 8'h06);
    pins(1'b1, 1'b0, "R10 alarm1 on pin1 when route set");

    // R8 status writes
    wr(8'h10, 8'h02);
    rd(8'h10, 8'h02, "R8 write one keeps flag");
    pins(1'b1, 1'b0, "R8 pin held after write one");
    wr(8'h10, 8'h00);
    rd(8'h10, 8'h00, "R8 write zero clears flag");
    pins(1'b1, 1'b1, "R8 pin released after write zero");

    // R4 partial mask
    wr(8'h0C, 8'h10); wr(8'h0D, 8'h12);
    tk(8'h05, 8'h10, 8'h12, 8'h02);
    rd(8'h10, 8'h02, "R4 masked sec and wday");
    rd(8'h0E, 8'h80, "R7 read alarm1 wday");
    rd(8'h10, 8'h00, "R7 alarm1 read clears flag1");
    tk(8'h05, 8'h11, 8'h12, 8'h02);
    rd(8'h10, 8'h00, "R4 unmasked minute still compared");

    // R5 raw hour encoding
    tk(8'h30, 8'h15, 8'h48, 8'h03);
    rd(8'h10, 8'h00, "R5 24h alarm vs 12h time");
    wr(8'h09, 8'h48);
    tk(8'h30, 8'h15, 8'h48, 8'h03);
    rd(8'h10, 8'h01, "R5 12h alarm matches 12h time");
    pins(1'b1, 1'b1, "R10 enable0 off keeps pin0 high");

    // R11 match and ack together
    tk_rd(8'h30, 8'h15, 8'h48, 8'h03, 8'h07, 8'h30, "R11 read data during match");
    rd(8'h10, 8'h01, "R11 match wins over ack");
    rd(8'h07, 8'h30, "R11 later read");
    rd(8'h10, 8'h00, "R11 later read clears");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule